// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block tracks loads that a scheduler has moved ahead of older stores. When a speculative load issues, it places an entry that holds its destination register tag and the address it read. Every store address is then compared in parallel against all live entries. A match means the hoisted load may have read stale data, so that entry is discarded.

At the load's original program position, a check operation names the destination register. The table answers one cycle later. The answer says either that the speculative value may be kept or that the load must run again. A check always frees the entry it names.

Storage is fully associative and keyed by register tag. When every slot is in use, a new load displaces an older one in rotating order. The displaced load then fails its check and is replayed. The result is safe, at the cost of some performance.

Top module: `ld_conflict_table`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes invalid, and `chk_done` and `chk_replay` read 0 after that edge.
- R2: A load insert (`ld_valid`) records its tag and address. A later check of that tag with no conflicting store in between returns `chk_replay` = 0.
- R3: A store conflicts with an entry when address bits [31:3] are equal, which is 8-byte granularity. A conflicting store invalidates the entry, so its check returns `chk_replay` = 1. A store to a different 8-byte block leaves the entry untouched.
- R4: A check of a tag that has no valid entry returns `chk_replay` = 1.
- R5: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high. `chk_replay` is meaningful in that cycle and 0 otherwise.
- R6: A check releases the entry it names, whatever the outcome. A second check of the same tag returns `chk_replay` = 1.
- R7: An insert whose tag is already held in a valid entry overwrites that entry's address in place. Only the new address is then compared against stores.
- R8: A new tag goes to the lowest-numbered free slot, judged by occupancy at the start of the cycle. If no slot is free, it replaces the slot named by a rotating pointer. The pointer starts at 0 after reset and steps by one, wrapping, on each replacement. A displaced load's check returns `chk_replay` = 1.
- R9: A store and a check that hit the same entry in the same cycle are ordered store first, so the check returns `chk_replay` = 1.
- R10: Same-cycle ordering for inserts. A store in the same cycle as an insert is compared only against entries that existed before, never against the incoming one. A check in the same cycle as an insert of the same tag sees the old entry, and the new entry survives the release.
- R11: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Speculative load issues this cycle |
| ld_tag | input | 6 | Destination register of the speculative load |
| ld_addr | input | 32 | Address read by the speculative load |
| st_valid | input | 1 | Store address presented this cycle |
| st_addr | input | 32 | Store address |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | 6 | Destination register being checked |
| chk_done | output | 1 | Check response valid, one cycle after `chk_valid` |
| chk_replay | output | 1 | 1 when the checked load must be executed again |

## Verification
The assertions cover several properties on every cycle. Tags in live entries stay unique, and an insert always leaves its tag present. A check always removes its tag from the table. A check of an absent tag always asks for replay, and the response timing is fixed. Behaviours that depend on the order of many operations can only be shown by the bench scenarios. These are conflict detection at 8-byte granularity, overwrite in place, free-slot preference over rotating replacement and same-cycle ordering of store, check and insert. The bench compares them against a reference model of the table.

// File: rtl/lct_pkg.sv
package lct_pkg;

  // How an incoming load obtains its slot.
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_REUSE,
    SEL_FREE,
    SEL_EVICT
  } alloc_kind_e;

endpackage

// File: rtl/lct_cam.sv
module lct_cam #(
  parameter int N     = 16,
  parameter int TAG_W = 6,
  parameter int BLK_W = 29
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [N-1:0][BLK_W-1:0] ent_blk,
  input  logic                    st_valid,
  input  logic [BLK_W-1:0]        st_blk,
  input  logic                    chk_valid,
  input  logic [TAG_W-1:0]        chk_tag,
  input  logic                    ins_valid,
  input  logic [TAG_W-1:0]        ins_tag,
  output logic [N-1:0]            st_hit,
  output logic [N-1:0]            chk_hit,
  output logic [N-1:0]            ins_hit
);

  // One comparator set per entry, all evaluated in parallel.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign st_hit[i]  = ent_valid[i] & st_valid  & (ent_blk[i] == st_blk);
    assign chk_hit[i] = ent_valid[i] & chk_valid & (ent_tag[i] == chk_tag);
    assign ins_hit[i] = ent_valid[i] & ins_valid & (ent_tag[i] == ins_tag);
  end

endmodule

// File: rtl/lct_alloc.sv
module lct_alloc
  import lct_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ins_valid,
  input  logic [N-1:0] ent_valid,
  input  logic [N-1:0] ins_hit,
  output logic [N-1:0] wr_vec
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] hit_idx, free_idx, sel;
  alloc_kind_e      kind;

  // Priority encoders: lowest index wins.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ins_hit[i])    hit_idx  = IDX_W'(i);
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    kind = SEL_NONE;
    sel  = '0;
    if (ins_valid) begin
      if (|ins_hit) begin
        kind = SEL_REUSE;
        sel  = hit_idx;
      end else if (!(&ent_valid)) begin
        kind = SEL_FREE;
        sel  = free_idx;
      end else begin
        kind = SEL_EVICT;
        sel  = rr_q;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_wr
    assign wr_vec[i] = (kind != SEL_NONE) && (sel == IDX_W'(i));
  end

  // Rotating victim pointer moves only on a real replacement.
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (kind == SEL_EVICT) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/lct_entries.sv
module lct_entries #(
  parameter int N     = 16,
  parameter int TAG_W = 6,
  parameter int BLK_W = 29
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0]            wr_vec,
  input  logic [N-1:0]            kill_vec,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [BLK_W-1:0]        wr_blk,
  output logic [N-1:0]            ent_valid,
  output logic [N-1:0][TAG_W-1:0] ent_tag,
  output logic [N-1:0][BLK_W-1:0] ent_blk
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    // Valid bit: a write outranks a kill in the same cycle.
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[i] <= 1'b0;
      end else if (wr_vec[i]) begin
        ent_valid[i] <= 1'b1;
      end else if (kill_vec[i]) begin
        ent_valid[i] <= 1'b0;
      end
    end

    // Payload needs no reset; it is qualified by the valid bit.
    always_ff @(posedge clk) begin
      if (wr_vec[i]) begin
        ent_tag[i] <= wr_tag;
        ent_blk[i] <= wr_blk;
      end
    end
  end

endmodule

// File: rtl/ld_conflict_table.sv
module ld_conflict_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_done,
  output logic              chk_replay
);

  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0] st_blk, ld_blk;
  logic             unused_low;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][BLK_W-1:0] ent_blk;
  logic [ENTRIES-1:0]            st_hit, chk_hit, ins_hit, wr_vec, kill_vec;
  logic                          chk_clean;

  // Only the block part of an address takes part in conflicts.
  assign st_blk     = st_addr[ADDR_W-1:OFF_W];
  assign ld_blk     = ld_addr[ADDR_W-1:OFF_W];
  assign unused_low = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

  lct_cam #(.N(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_cam (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_blk   (ent_blk),
    .st_valid  (st_valid),
    .st_blk    (st_blk),
    .chk_valid (chk_valid),
    .chk_tag   (chk_tag),
    .ins_valid (ld_valid),
    .ins_tag   (ld_tag),
    .st_hit    (st_hit),
    .chk_hit   (chk_hit),
    .ins_hit   (ins_hit)
  );

  lct_alloc #(.N(ENTRIES)) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ld_valid),
    .ent_valid (ent_valid),
    .ins_hit   (ins_hit),
    .wr_vec    (wr_vec)
  );

  // Both a conflicting store and a check retire an entry.
  assign kill_vec = st_hit | chk_hit;

  lct_entries #(.N(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_entries (
    .clk       (clk),
    .rst       (rst),
    .wr_vec    (wr_vec),
    .kill_vec  (kill_vec),
    .wr_tag    (ld_tag),
    .wr_blk    (ld_blk),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_blk   (ent_blk)
  );

  // The store of this cycle is applied before the check looks.
  assign chk_clean = |(chk_hit & ~st_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_done   <= 1'b0;
      chk_replay <= 1'b0;
    end else begin
      chk_done   <= chk_valid;
      chk_replay <= chk_valid & ~chk_clean;
    end
  end

endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
  parameter int N     = 16,
  parameter int TAG_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ld_valid,
  input logic [TAG_W-1:0]        ld_tag,
  input logic                    chk_valid,
  input logic [TAG_W-1:0]        chk_tag,
  input logic                    chk_done,
  input logic                    chk_replay,
  input logic [N-1:0]            valid_q,
  input logic [N-1:0][TAG_W-1:0] tag_q
);

  function automatic logic has_tag(input logic [TAG_W-1:0] t);
    logic f;
    f = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid_q[i] && tag_q[i] == t) f = 1'b1;
    end
    return f;
  endfunction

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!chk_done && !chk_replay && valid_q == '0));

  // R2
  insert_present_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> has_tag($past(ld_tag)));

  // R4
  miss_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !has_tag(chk_tag)) |=> chk_replay);

  // R5
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!chk_done && !chk_replay));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !(ld_valid && ld_tag == chk_tag)) |=> !has_tag($past(chk_tag)));

  // R11
  unique_tag_chk: assert property (@(posedge clk) disable iff (rst) !dup);

endmodule

bind ld_conflict_table lct_checker #(.N(ENTRIES), .TAG_W(TAG_W)) u_lct_checker (
  .clk        (clk),
  .rst        (rst),
  .ld_valid   (ld_valid),
  .ld_tag     (ld_tag),
  .chk_valid  (chk_valid),
  .chk_tag    (chk_tag),
  .chk_done   (chk_done),
  .chk_replay (chk_replay),
  .valid_q    (ent_valid),
  .tag_q      (ent_tag)
);

// File: tb/test_ld_conflict_table.sv
`timescale 1ns/1ps
module test_ld_conflict_table;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, st_valid, chk_valid;
  logic [5:0]  ld_tag, chk_tag;
  logic [31:0] ld_addr, st_addr;
  logic        chk_done, chk_replay;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ld_conflict_table i_ld_conflict_table (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_tag(chk_tag),
    .chk_done(chk_done), .chk_replay(chk_replay)
  );

  // Reference model of the table
  logic        m_v [N];
  logic [5:0]  m_t [N];
  logic [28:0] m_b [N];
  int          m_rr;

  function automatic logic [28:0] blk(input logic [31:0] a);
    return a[31:3];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic model_step(input logic iv, input logic [5:0] it, input logic [31:0] ia,
                            input logic sv, input logic [31:0] sa,
                            input logic cv, input logic [5:0] ct, output logic rep);
    logic sh [N];
    logic ch [N];
    logic clean;
    int   slot;
    clean = 1'b0;
    slot  = -1;
    for (int i = 0; i < N; i++) begin
      sh[i] = m_v[i] && sv && blk(m_b[i] << 3) == blk(sa);
      ch[i] = m_v[i] && cv && m_t[i] == ct;
      if (ch[i] && !sh[i]) clean = 1'b1;
    end
    rep = cv && !clean;
    if (iv) begin
      for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_t[i] == it) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
    end
    for (int i = 0; i < N; i++) if (sh[i] || ch[i]) m_v[i] = 1'b0;
    if (slot >= 0) begin
      m_v[slot] = 1'b1;
      m_t[slot] = it;
      m_b[slot] = blk(ia);
    end
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 1'b0; ld_tag = '0; ld_addr = '0;
    st_valid = 1'b0; st_addr = '0;
    chk_valid = 1'b0; chk_tag = '0;
  endtask

  // Drive one cycle at the falling edge, sample at the next falling edge.
  task automatic op(input logic iv, input logic [5:0] it, input logic [31:0] ia,
                    input logic sv, input logic [31:0] sa,
                    input logic cv, input logic [5:0] ct, input string req);
    logic rep;
    ld_valid = iv; ld_tag = it; ld_addr = ia;
    st_valid = sv; st_addr = sa;
    chk_valid = cv; chk_tag = ct;
    model_step(iv, it, ia, sv, sa, cv, ct, rep);
    @(posedge clk);
    @(negedge clk);
    check(chk_done == cv, "R5 done", int'(chk_done), int'(cv));
    if (cv) check(chk_replay == rep, req, int'(chk_replay), int'(rep));
    else    check(chk_replay == 1'b0, "R5 replay idle", int'(chk_replay), 0);
    idle();
  endtask

  task automatic ins(input logic [5:0] t, input logic [31:0] a);
    op(1'b1, t, a, 1'b0, '0, 1'b0, '0, "R2");
  endtask
  task automatic st(input logic [31:0] a);
    op(1'b0, '0, '0, 1'b1, a, 1'b0, '0, "R3");
  endtask
  task automatic chk(input logic [5:0] t, input string req);
    op(1'b0, '0, '0, 1'b0, '0, 1'b1, t, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle();
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    rst = 1'b1;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    check(chk_done == 1'b0, "R1 done", int'(chk_done), 0);
    check(chk_replay == 1'b0, "R1 replay", int'(chk_replay), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R4: empty table after reset, any check misses
    chk(6'd5, "R4 empty table");

    // R2: clean load survives
    ins(6'd1, 32'h1000);
    chk(6'd1, "R2 clean");

    // R3: other block has no effect, same block conflicts
    ins(6'd2, 32'h2000);
    st(32'h2008);
    chk(6'd2, "R3 other block");
    ins(6'd3, 32'h3000);
    st(32'h3007);
    chk(6'd3, "R3 same block");

    // R6: second check after release
    chk(6'd2, "R6 released");

    // R7: overwrite in place
    ins(6'd4, 32'h4000);
    ins(6'd4, 32'h5000);
    st(32'h4000);
    chk(6'd4, "R7 old address ignored");
    ins(6'd4, 32'h6000);
    ins(6'd4, 32'h6100);
    st(32'h6100);
    chk(6'd4, "R7 new address used");

    // R9: store and check together
    ins(6'd5, 32'h7000);
    op(1'b0, '0, '0, 1'b1, 32'h7004, 1'b1, 6'd5, "R9 store first");

    // R10: store beside insert misses the newcomer
    op(1'b1, 6'd6, 32'h8000, 1'b1, 32'h8000, 1'b0, '0, "R10");
    chk(6'd6, "R10 store skips new");
    // R10: check beside insert of same tag
    ins(6'd7, 32'h9000);
    op(1'b1, 6'd7, 32'hA000, 1'b0, '0, 1'b1, 6'd7, "R10 check old");
    chk(6'd7, "R10 new survives");

    // R8: fill, replace in rotation, prefer free slot
    do_reset();
    for (int i = 0; i < N; i++) ins(6'(10 + i), 32'(32'h10000 + i * 64));
    ins(6'd40, 32'h20000);
    ins(6'd41, 32'h20040);
    chk(6'd20, "R8 resident");
    ins(6'd42, 32'h20080);
    chk(6'd12, "R8 free slot preferred");
    chk(6'd42, "R8 new entry");
    chk(6'd10, "R8 displaced first");
    chk(6'd11, "R8 displaced second");
    chk(6'd40, "R8 replacement kept");

    // Constrained random traffic against the model (R3, R7, R8, R9)
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic iv, sv, cv;
      logic [5:0] it, ct;
      logic [31:0] ia, sa;
      iv = ($urandom % 100) < 55;
      sv = ($urandom % 100) < 35;
      cv = ($urandom % 100) < 40;
      it = 6'($urandom % 24);
      ct = 6'($urandom % 24);
      ia = {24'h0, 5'($urandom % 32), 3'($urandom % 8)};
      sa = {24'h0, 5'($urandom % 32), 3'($urandom % 8)};
      op(iv, it, ia, sv, sa, cv, ct, "R3 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule